// File: doc/BRIEF.md
# Flash Bank Read Conflict Resolver

This block is the read path between an AHB-Lite slave port and a single flash array bank. Each accepted read transfer becomes a multi-cycle array access: the bank read enable is held with a registered address for a fixed number of cycles. The returned word is then presented on the bus. The bank can start a high-voltage program or erase at any time. It signals this by lowering its ready ("done") input. If that happens while an access is under way, the access is spoilt and has to be resolved.

A 3-bit policy input selects how the block resolves the conflict. With the upper two bits at binary 10, the block cancels the array operation by raising an abort output. It keeps the abort raised until the bank reports ready again. It then starts the same read over from its first cycle. With any other upper-bit value, the block raises no abort. It idles the bank until ready returns and then repeats the read. In both cases bit 0 of the policy decides whether a one-cycle notification pulse is sent. The terminate policies use a termination pulse and the other policies use a stall pulse. The bus sees only a longer wait. The transfer in its data phase and any transfer waiting in its address phase both stay stalled until the retried word is delivered.

Top module: `flash_rww_ctrl`

## Requirements
- R1: While reset is applied, hready_out is 1, hresp is 0 (OKAY), hrdata is 0, and bk_rd_en, bk_abort, irq_term and irq_stall are all 0.
- R2: A read transfer is accepted when hsel=1, hready_in=1, hwrite=0, htrans is 2'b10 or 2'b11, and hready_out=1. From the next cycle, bk_rd_en is 1 with bk_addr equal to the accepted address for READ_WAIT+1 cycles while hready_out is 0. The following cycle has hready_out=1, hresp=0, and hrdata equal to bk_rdata sampled in the last access cycle.
- R3: Write transfers and htrans values 2'b00 and 2'b01 start no bank read and leave hready_out at 1. bk_done low while no access is running causes no abort and no interrupt.
- R4: If bk_done is 0 during any access cycle, that access is abandoned. After bk_done is seen at 1, the read to the same address is reissued and runs all READ_WAIT+1 access cycles again.
- R5: When rww_policy[2:1]=2'b10, bk_abort is 1 from the cycle after the conflict up to and including the cycle in which bk_done is sampled 1. bk_rd_en is 0 while bk_abort is 1. In the next cycle bk_abort is 0 and bk_rd_en is 1.
- R6: With rww_policy=3'b100, irq_term pulses high for exactly one cycle: the first abort cycle. With 3'b101 it stays 0.
- R7: With rww_policy[2:1] other than 2'b10, bk_abort stays 0 and the bank is idle until bk_done is 1. irq_stall pulses for one cycle in the first waiting cycle when rww_policy[0]=0, and stays 0 when it is 1.
- R8: hready_out stays 0 from the first access cycle until the retried word is delivered. hresp stays 0 throughout. A read held in the address phase meanwhile does not change bk_addr.
- R9: If bk_xfr_err=1 in the final access cycle with bk_done=1, the response is one cycle of hready_out=0 with hresp=1, then one cycle of hready_out=1 with hresp=1.
- R10: A read accepted in the completion cycle of the previous read starts its first access cycle on the next clock, with no idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hclk | input | 1 | Bus and bank clock |
| hresetn | input | 1 | Asynchronous active-low reset, released synchronously inside |
| hsel | input | 1 | Slave select |
| hready_in | input | 1 | Bus-level ready from the interconnect |
| htrans | input | 2 | Transfer type |
| haddr | input | ADDR_W | Transfer address |
| hwrite | input | 1 | Write indicator (writes are not serviced) |
| hrdata | output | DATA_W | Read data |
| hready_out | output | 1 | Slave ready |
| hresp | output | 1 | 0 = OKAY, 1 = ERROR |
| rww_policy | input | 3 | Conflict resolution policy |
| bk_addr | output | ADDR_W | Bank read address |
| bk_rd_en | output | 1 | Bank read enable |
| bk_rdata | input | DATA_W | Bank read data |
| bk_xfr_err | input | 1 | Bank transfer error |
| bk_done | input | 1 | Bank ready; 0 while a program or erase is running |
| bk_abort | output | 1 | Cancel the running program or erase |
| irq_stall | output | 1 | Stall notification pulse |
| irq_term | output | 1 | Termination notification pulse |

## Verification
The bench builds the block with READ_WAIT=2, ADDR_W=16 and DATA_W=32. That gives a three-cycle access, so a conflict can be placed on the first, middle or last access cycle. The bench covers those three positions together with busy periods of one to four cycles, which reaches both the shortest and the longest abort and stall windows. With 16-bit addresses, the retried address and the held address-phase address (four higher) can be told apart at bk_addr in every case.

// File: rtl/frww_pkg.sv
package frww_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACCESS,
    ST_ABORT,
    ST_HOLD,
    ST_DONE,
    ST_ERR1,
    ST_ERR2
  } seq_state_e;

  localparam logic [1:0] HT_NONSEQ = 2'b10;
  localparam logic [1:0] HT_SEQ    = 2'b11;

  // upper policy bits 10: cancel the high-voltage operation
  function automatic logic pol_terminates(input logic [2:0] pol);
    return pol[2:1] == 2'b10;
  endfunction

  // policy bit 0 low: send a notification pulse
  function automatic logic pol_notifies(input logic [2:0] pol);
    return ~pol[0];
  endfunction

endpackage

// File: rtl/frww_addr_stage.sv
module frww_addr_stage
  import frww_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hsel,
  input  logic              hready_in,
  input  logic [1:0]        htrans,
  input  logic              hwrite,
  input  logic [ADDR_W-1:0] haddr,
  input  logic              slot_free,
  output logic              accept,
  output logic [ADDR_W-1:0] bank_addr
);

  logic              is_read;
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] addr_d;

  always_comb begin
    is_read = hsel && hready_in && !hwrite &&
              ((htrans == HT_NONSEQ) || (htrans == HT_SEQ));
    accept  = is_read && slot_free;
    addr_d  = accept ? haddr : addr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr_q <= '0;
    else        addr_q <= addr_d;
  end

  assign bank_addr = addr_q;

  // R8: a stalled bus never moves the bank address
  p_addr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_free |=> $stable(bank_addr));

endmodule

// File: rtl/frww_rdata_hold.sv
module frww_rdata_hold #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic [DATA_W-1:0] bk_rdata,
  output logic [DATA_W-1:0] hrdata
);

  logic [DATA_W-1:0] data_q;
  logic [DATA_W-1:0] data_d;

  always_comb data_d = cap_en ? bk_rdata : data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) data_q <= '0;
    else        data_q <= data_d;
  end

  assign hrdata = data_q;

endmodule

// File: rtl/frww_access_seq.sv
module frww_access_seq
  import frww_pkg::*;
#(
  parameter int READ_WAIT = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       accept,
  input  logic [2:0] policy,
  input  logic       bk_done,
  input  logic       bk_xfr_err,
  output logic       bk_rd_en,
  output logic       bk_abort,
  output logic       slot_free,
  output logic       err_resp,
  output logic       cap_en,
  output logic       irq_term,
  output logic       irq_stall
);

  localparam int              CNT_W    = (READ_WAIT > 0) ? $clog2(READ_WAIT + 1) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(READ_WAIT);

  seq_state_e       st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             term_d, term_q;
  logic             stall_d, stall_q;
  logic             last_beat;

  assign last_beat = (cnt_q == CNT_LAST);

  // next-state process
  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    term_d  = 1'b0;
    stall_d = 1'b0;
    case (st_q)
      ST_IDLE, ST_DONE, ST_ERR2: begin
        // R10: a new read starts directly from a completion cycle
        cnt_en = 1'b1;
        cnt_d  = '0;
        st_d   = accept ? ST_ACCESS : ST_IDLE;
      end
      ST_ACCESS: begin
        cnt_en = 1'b1;
        if (!bk_done) begin
          cnt_d = '0;
          if (pol_terminates(policy)) begin
            st_d   = ST_ABORT;
            term_d = pol_notifies(policy);
          end else begin
            st_d    = ST_HOLD;
            stall_d = pol_notifies(policy);
          end
        end else if (last_beat) begin
          cnt_d = '0;
          st_d  = bk_xfr_err ? ST_ERR1 : ST_DONE;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_ABORT, ST_HOLD: begin
        if (bk_done) begin
          cnt_en = 1'b1;
          cnt_d  = '0;
          st_d   = ST_ACCESS;
        end
      end
      ST_ERR1: st_d = ST_ERR2;
      default: st_d = ST_IDLE;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      term_q  <= 1'b0;
      stall_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      term_q  <= term_d;
      stall_q <= stall_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign bk_rd_en  = (st_q == ST_ACCESS);
  assign bk_abort  = (st_q == ST_ABORT);
  assign slot_free = (st_q == ST_IDLE) || (st_q == ST_DONE) || (st_q == ST_ERR2);
  assign err_resp  = (st_q == ST_ERR1) || (st_q == ST_ERR2);
  assign cap_en    = (st_q == ST_ACCESS) && bk_done && last_beat && !bk_xfr_err;
  assign irq_term  = term_q;
  assign irq_stall = stall_q;

  // R4: a conflict ends the access and keeps the bus stalled
  p_conflict_stops_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bk_rd_en && !bk_done) |=> (!bk_rd_en && !slot_free));

  // R5: abort and read are never driven together
  p_abort_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bk_abort |-> !bk_rd_en);

  // R5: abort persists while the bank is still busy
  p_abort_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bk_abort && !bk_done) |=> bk_abort);

  // R5: abort drops as the retry read issues
  p_abort_retry_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bk_abort && bk_done) |=> (!bk_abort && bk_rd_en));

  // R6: termination pulse is one cycle, inside the abort window
  p_term_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_term |=> !irq_term);
  p_term_in_abort_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_term |-> bk_abort);

  // R7: stall pulse only while waiting with an idle bank
  p_stall_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_stall |-> (!bk_abort && !bk_rd_en && !irq_term));
  p_stall_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_stall |=> !irq_stall);

  // R9: error response is the two-cycle sequence
  p_err_seq_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (err_resp && !slot_free) |=> (err_resp && slot_free));

endmodule

// File: rtl/flash_rww_ctrl.sv
module flash_rww_ctrl #(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 32,
  parameter int READ_WAIT = 2
) (
  input  logic              hclk,
  input  logic              hresetn,
  input  logic              hsel,
  input  logic              hready_in,
  input  logic [1:0]        htrans,
  input  logic [ADDR_W-1:0] haddr,
  input  logic              hwrite,
  output logic [DATA_W-1:0] hrdata,
  output logic              hready_out,
  output logic              hresp,
  input  logic [2:0]        rww_policy,
  output logic [ADDR_W-1:0] bk_addr,
  output logic              bk_rd_en,
  input  logic [DATA_W-1:0] bk_rdata,
  input  logic              bk_xfr_err,
  input  logic              bk_done,
  output logic              bk_abort,
  output logic              irq_stall,
  output logic              irq_term
);

  logic [1:0] rst_pipe_q;
  logic       rst_n_core;
  logic       accept;
  logic       slot_free;
  logic       err_resp;
  logic       cap_en;

  // asynchronous assertion, synchronous release
  always_ff @(posedge hclk or negedge hresetn) begin
    if (!hresetn) rst_pipe_q <= '0;
    else          rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_core = rst_pipe_q[1];

  frww_addr_stage #(.ADDR_W(ADDR_W)) u_addr (
    .clk       (hclk),
    .rst_n     (rst_n_core),
    .hsel      (hsel),
    .hready_in (hready_in),
    .htrans    (htrans),
    .hwrite    (hwrite),
    .haddr     (haddr),
    .slot_free (slot_free),
    .accept    (accept),
    .bank_addr (bk_addr)
  );

  frww_access_seq #(.READ_WAIT(READ_WAIT)) u_seq (
    .clk        (hclk),
    .rst_n      (rst_n_core),
    .accept     (accept),
    .policy     (rww_policy),
    .bk_done    (bk_done),
    .bk_xfr_err (bk_xfr_err),
    .bk_rd_en   (bk_rd_en),
    .bk_abort   (bk_abort),
    .slot_free  (slot_free),
    .err_resp   (err_resp),
    .cap_en     (cap_en),
    .irq_term   (irq_term),
    .irq_stall  (irq_stall)
  );

  frww_rdata_hold #(.DATA_W(DATA_W)) u_rdata (
    .clk      (hclk),
    .rst_n    (rst_n_core),
    .cap_en   (cap_en),
    .bk_rdata (bk_rdata),
    .hrdata   (hrdata)
  );

  assign hready_out = slot_free;
  assign hresp      = err_resp;

  // R8: OKAY only while waiting, unless the error sequence is running
  p_okay_while_busy_r8: assert property (@(posedge hclk) disable iff (!rst_n_core)
    (bk_rd_en || bk_abort) |-> (!hresp && !hready_out));

endmodule

// File: tb/flash_rww_ctrl_bench.sv
`timescale 1ns/1ps
module flash_rww_ctrl_bench;

  localparam int AW = 16;
  localparam int DW = 32;
  localparam int W  = 2;

  typedef struct packed {
    logic [15:0] addr;
    logic [2:0]  pol;
    logic [7:0]  k;
    logic [7:0]  len;
    logic        err;
  } vec_t;

  // addr, policy, conflict cycle, busy length, transfer error
  localparam vec_t VECS [0:7] = '{
    '{16'h0100, 3'b000, 8'd0, 8'd0, 1'b0},
    '{16'h0204, 3'b100, 8'd1, 8'd2, 1'b0},
    '{16'h0308, 3'b101, 8'd2, 8'd1, 1'b0},
    '{16'h040C, 3'b010, 8'd0, 8'd3, 1'b0},
    '{16'h0510, 3'b011, 8'd1, 8'd1, 1'b0},
    '{16'h0614, 3'b100, 8'd0, 8'd1, 1'b1},
    '{16'h0718, 3'b000, 8'd0, 8'd0, 1'b1},
    '{16'h081C, 3'b111, 8'd2, 8'd4, 1'b0}
  };

  logic          hclk = 1'b0;
  logic          hresetn;
  logic          hsel, hready_in, hwrite;
  logic [1:0]    htrans;
  logic [AW-1:0] haddr;
  logic [DW-1:0] hrdata;
  logic          hready_out, hresp;
  logic [2:0]    rww_policy;
  logic [AW-1:0] bk_addr;
  logic          bk_rd_en;
  logic [DW-1:0] bk_rdata;
  logic          bk_xfr_err, bk_done, bk_abort, irq_stall, irq_term;

  int total = 0;
  int bad   = 0;

  always #2 hclk = ~hclk;

  // bank data model: word derived from the address
  function automatic logic [DW-1:0] model_data(input logic [AW-1:0] a);
    return {~a, a};
  endfunction
  assign bk_rdata = model_data(bk_addr);

  flash_rww_ctrl #(.ADDR_W(AW), .DATA_W(DW), .READ_WAIT(W)) u_flash_rww_ctrl (
    .hclk(hclk), .hresetn(hresetn), .hsel(hsel), .hready_in(hready_in),
    .htrans(htrans), .haddr(haddr), .hwrite(hwrite), .hrdata(hrdata),
    .hready_out(hready_out), .hresp(hresp), .rww_policy(rww_policy),
    .bk_addr(bk_addr), .bk_rd_en(bk_rd_en), .bk_rdata(bk_rdata),
    .bk_xfr_err(bk_xfr_err), .bk_done(bk_done), .bk_abort(bk_abort),
    .irq_stall(irq_stall), .irq_term(irq_term)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_read(input logic [AW-1:0] a, input logic [2:0] pol, input int k,
                          input int len, input logic err, input logic chain, input logic pre);
    int c = 0, lows = 0, rdc = 0, abc = 0, tpc = 0, spc = 0, addr_bad = 0, resp_busy = 0;
    int exp_lows, exp_rdc, exp_ab, exp_tp, exp_sp;
    logic fin = 1'b0;
    rww_policy = pol;
    if (!pre) begin
      @(negedge hclk);
      hsel = 1'b1; hwrite = 1'b0; htrans = 2'b10; haddr = a;
    end
    while (!fin && c < 200) begin
      @(negedge hclk);
      if (irq_term)  tpc++;
      if (irq_stall) spc++;
      if (hready_out) begin
        fin = 1'b1;
        exp_lows = ((len > 0) ? (k + len + 2 + W) : (W + 1)) + (err ? 1 : 0);
        exp_rdc  = ((len > 0) ? (k + 1) : 0) + W + 1;
        exp_ab   = (pol[2:1] == 2'b10 && len > 0) ? len : 0;
        exp_tp   = (pol == 3'b100 && len > 0) ? 1 : 0;
        exp_sp   = (pol[2:1] != 2'b10 && !pol[0] && len > 0) ? 1 : 0;
        chk("R8 stall length", lows, exp_lows);
        chk("R4 read cycles incl retry", rdc, exp_rdc);
        chk("R4 retry address", addr_bad, 0);
        chk("R5 abort cycles", abc, exp_ab);
        chk("R6 term pulses", tpc, exp_tp);
        chk("R7 stall pulses", spc, exp_sp);
        chk("R9 hresp at completion", hresp, err);
        chk("R8 hresp while waiting", resp_busy, err ? 1 : 0);
        if (!err) chk("R2 read data", hrdata, model_data(a));
        bk_done = 1'b1; bk_xfr_err = 1'b0;
        if (!chain) htrans = 2'b00;
      end else begin
        lows++;
        if (hresp) resp_busy++;
        if (bk_rd_en) begin
          rdc++;
          if (bk_addr != a) addr_bad++;
        end
        if (bk_abort) abc++;
        bk_done    = !(len > 0 && c >= k && c < k + len);
        bk_xfr_err = err;
        htrans     = chain ? 2'b10 : 2'b00;
        haddr      = chain ? a + 16'd4 : a;
      end
      c++;
    end
    if (!fin) chk("R8 completion reached", 0, 1);
  endtask

  initial begin
    repeat (20000) @(posedge hclk);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    hresetn = 1'b0; hsel = 1'b0; hready_in = 1'b1; hwrite = 1'b0;
    htrans = 2'b00; haddr = '0; rww_policy = 3'b000;
    bk_xfr_err = 1'b0; bk_done = 1'b1;
    repeat (3) @(negedge hclk);
    // R1 reset state
    chk("R1 hready_out", hready_out, 1);
    chk("R1 hresp", hresp, 0);
    chk("R1 hrdata", hrdata, 0);
    chk("R1 bk_rd_en", bk_rd_en, 0);
    chk("R1 bk_abort", bk_abort, 0);
    chk("R1 irqs", {irq_term, irq_stall}, 0);
    hresetn = 1'b1;
    repeat (4) @(negedge hclk);

    for (int i = 0; i < 8; i++)
      run_read(VECS[i].addr, VECS[i].pol, int'(VECS[i].k), int'(VECS[i].len),
               VECS[i].err, 1'b0, 1'b0);

    // R3: write transfer and idle busy bank are ignored
    @(negedge hclk);
    hsel = 1'b1; hwrite = 1'b1; htrans = 2'b10; haddr = 16'h0F00;
    rww_policy = 3'b100;
    @(negedge hclk);
    htrans = 2'b01; hwrite = 1'b0; bk_done = 1'b0;
    for (int j = 0; j < 4; j++) begin
      @(negedge hclk);
      chk("R3 no read on write/busy", bk_rd_en, 0);
      chk("R3 hready stays high", hready_out, 1);
      chk("R3 no abort while idle", bk_abort, 0);
      chk("R3 no irq while idle", {irq_term, irq_stall}, 0);
    end
    htrans = 2'b00; bk_done = 1'b1;

    // R8/R10: next read held in address phase, then back to back
    run_read(16'h0A00, 3'b100, 1, 2, 1'b0, 1'b1, 1'b0);
    run_read(16'h0A04, 3'b000, 0, 0, 1'b0, 1'b0, 1'b1);

    // R10: a conflict on the last access cycle, chained reads
    run_read(16'h0B00, 3'b010, 2, 2, 1'b0, 1'b1, 1'b0);
    run_read(16'h0B04, 3'b101, 0, 1, 1'b0, 1'b0, 1'b1);

    repeat (3) @(negedge hclk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule